// File: doc/BRIEF.md
# Prefetch Read Buffer with Burst Hold-off

This block is a synchronous first-in first-out buffer that sits on the read-data path between a user data source and a bus-side consumer. The source pushes one word on every cycle its write enable is high. The bus side pops words from the head, and the head word is always visible on the read-data output. All status flags are active-low and are decoded from registered occupancy state. Full and almost-full go to the writer so it can throttle itself with some latency to spare. The empty flag goes to the reader.

A hold-off input changes when the reader is told that data is present. While hold-off is high, the buffer keeps reporting empty until it has filled completely. It then reports nonempty until it has drained to zero, so the bus side can move a whole buffer as one uninterrupted burst. A flush input drops any surplus prefetched words at the end of a transaction, so that the next transaction starts from an empty buffer.

A parameter selects one of two shapes: a narrow shape for a 32-bit bus and a wide shape for a 64-bit bus. Each word carries extra side bits, which are stored but not interpreted.

Top module: `pfifo_top`

## Requirements
- R1: With `SHAPE` = narrow the buffer holds 32 words of 36 bits. With `SHAPE` = wide it holds 16 words of 72 bits.
- R2: Words leave in the order they were accepted. Whenever `empty_n` is high, `rd_data` shows the oldest stored word, and a cycle with `rd_en` high removes that word at the clock edge.
- R3: `full_n` is low exactly when every location is occupied. A write while `full_n` is low is ignored and stores nothing.
- R4: `afull_n` is low exactly when four or fewer locations are free.
- R5: With `hold` low, `empty_n` is low exactly when the buffer holds no word. A read while `empty_n` is low is ignored and removes nothing.
- R6: With `hold` high, `empty_n` stays low while the buffer fills, goes high once it is completely full, and then stays high until the buffer is truly empty.
- R7: A cycle that both writes and reads while neither full nor reported empty leaves the occupancy unchanged. The flags can therefore move in either direction within one burst.
- R8: `flush` high empties the buffer at the clock edge and closes the hold-off gate. A write or read in the same cycle is discarded.
- R9: After synchronous reset, `empty_n` is 0, `full_n` is 1 and `afull_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| flush | input | 1 | Discard all stored words and close the hold-off gate |
| hold | input | 1 | Suppress the nonempty indication until the buffer is full |
| wr_en | input | 1 | Push `wr_data` this cycle |
| wr_data | input | 36 or 72 | Word from the data source (width set by `SHAPE`) |
| full_n | output | 1 | Low when no location is free |
| afull_n | output | 1 | Low when four or fewer locations are free |
| rd_en | input | 1 | Pop the head word this cycle |
| rd_data | output | 36 or 72 | Oldest stored word |
| empty_n | output | 1 | Low when the reader must treat the buffer as empty |

## Verification
The bench instantiates both shapes side by side and drives them with identical stimulus. It pushes each one past full and pops past empty. If a design failed to block these accesses, its occupancy would wrap, and it would report nonempty with stale data or lose the oldest word. Simultaneous reads and writes are exercised at the almost-full edge, where an off-by-one threshold or a miscounted paired access shows up as an almost-full flag that flips when it should hold. Hold-off runs are made with read requests held high throughout. A design that opened its gate early would leak words before the buffer was full, and one that closed the gate at the first pop would split the burst. Flushes that coincide with writes check that no word survives into the next transaction.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef enum logic {
        BUS_NARROW = 1'b0,
        BUS_WIDE   = 1'b1
    } bus_shape_e;

    localparam int NARROW_WORD  = 36;
    localparam int NARROW_DEPTH = 32;
    localparam int WIDE_WORD    = 72;
    localparam int WIDE_DEPTH   = 16;
    localparam int AFULL_SLACK  = 4;

    function automatic int word_bits(bus_shape_e shape);
        return (shape == BUS_WIDE) ? WIDE_WORD : NARROW_WORD;
    endfunction

    function automatic int entry_count(bus_shape_e shape);
        return (shape == BUS_WIDE) ? WIDE_DEPTH : NARROW_DEPTH;
    endfunction

    typedef struct packed {
        logic push;
        logic pop;
        logic clear;
    } fifo_ops_t;

endpackage

// File: rtl/pfb_storage.sv
module pfb_storage #(
    parameter int WORD_W = 36,
    parameter int DEPTH  = 32,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [WORD_W-1:0] rdata
);

    logic [WORD_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Head word falls through so the reader sees it without a request.
    assign rdata = mem[raddr];

endmodule

// File: rtl/pfb_ptr_ctrl.sv
module pfb_ptr_ctrl
    import pfb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  fifo_ops_t     ops,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] occ,
    output logic [CW-1:0] occ_nxt
);

    always_comb begin
        occ_nxt = occ;
        if (ops.clear) begin
            occ_nxt = '0;
        end else begin
            unique case ({ops.push, ops.pop})
                2'b10:   occ_nxt = occ + 1'b1;
                2'b01:   occ_nxt = occ - 1'b1;
                default: occ_nxt = occ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ops.clear) begin
            wptr <= '0;
            rptr <= '0;
            occ  <= '0;
        end else begin
            if (ops.push) wptr <= wptr + 1'b1;
            if (ops.pop)  rptr <= rptr + 1'b1;
            occ <= occ_nxt;
        end
    end

endmodule

// File: rtl/pfb_flag_gen.sv
module pfb_flag_gen
    import pfb_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clear,
    input  logic          hold,
    input  logic [CW-1:0] occ,
    input  logic [CW-1:0] occ_nxt,
    output logic          full_n,
    output logic          afull_n,
    output logic          empty_n
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] SLACK_C = CW'(AFULL_SLACK);

    // Burst gate: opens when the buffer reaches full, closes when it drains.
    logic          gate_open;
    logic [CW-1:0] free_slots;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            gate_open <= 1'b0;
        end else if (occ_nxt == DEPTH_C) begin
            gate_open <= 1'b1;
        end else if (occ_nxt == '0) begin
            gate_open <= 1'b0;
        end
    end

    assign free_slots = DEPTH_C - occ;
    assign full_n     = (occ != DEPTH_C);
    assign afull_n    = (free_slots > SLACK_C);
    assign empty_n    = (occ != '0) && (!hold || gate_open);

endmodule

// File: rtl/pfifo_top.sv
module pfifo_top
    import pfb_pkg::*;
#(
    parameter bus_shape_e SHAPE = BUS_NARROW,
    localparam int WORD_W = word_bits(SHAPE),
    localparam int DEPTH  = entry_count(SHAPE),
    localparam int AW     = $clog2(DEPTH),
    localparam int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              hold,
    input  logic              wr_en,
    input  logic [WORD_W-1:0] wr_data,
    output logic              full_n,
    output logic              afull_n,
    input  logic              rd_en,
    output logic [WORD_W-1:0] rd_data,
    output logic              empty_n
);

    fifo_ops_t     ops;
    logic [AW-1:0] wptr;
    logic [AW-1:0] rptr;
    logic [CW-1:0] occ;
    logic [CW-1:0] occ_nxt;

    // Accesses against a blocking flag are dropped; flush overrides both.
    always_comb begin
        ops.clear = flush;
        ops.push  = wr_en && full_n && !flush;
        ops.pop   = rd_en && empty_n && !flush;
    end

    pfb_ptr_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ops     (ops),
        .wptr    (wptr),
        .rptr    (rptr),
        .occ     (occ),
        .occ_nxt (occ_nxt)
    );

    pfb_storage #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .clk   (clk),
        .we    (ops.push),
        .waddr (wptr),
        .wdata (wr_data),
        .raddr (rptr),
        .rdata (rd_data)
    );

    pfb_flag_gen #(.DEPTH(DEPTH)) u_flags (
        .clk     (clk),
        .rst     (rst),
        .clear   (flush),
        .hold    (hold),
        .occ     (occ),
        .occ_nxt (occ_nxt),
        .full_n  (full_n),
        .afull_n (afull_n),
        .empty_n (empty_n)
    );

endmodule

// File: rtl/pfb_checker.sv
module pfb_checker #(
    parameter int DEPTH = 32,
    parameter int CW    = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          flush,
    input logic          hold,
    input logic          wr_en,
    input logic          rd_en,
    input logic          full_n,
    input logic          afull_n,
    input logic          empty_n,
    input logic [CW-1:0] occ
);

    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_en && !rd_en && !flush) |=> (occ == $past(occ)));

    assert_full_implies_afull_R4: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> !afull_n);

    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en && !wr_en && !flush) |=> (occ == $past(occ)));

    assert_gate_opens_at_full_R6: assert property (@(posedge clk) disable iff (rst)
        (hold && $past(hold) && $rose(empty_n)) |-> (occ == DEPTH_C));

    assert_paired_access_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && rd_en && full_n && empty_n && !flush) |=> $stable(occ));

    assert_flush_empties_R8: assert property (@(posedge clk) disable iff (rst)
        flush |=> (occ == '0 && !empty_n));

endmodule

bind pfifo_top pfb_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .flush   (flush),
    .hold    (hold),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .full_n  (full_n),
    .afull_n (afull_n),
    .empty_n (empty_n),
    .occ     (occ)
);

// File: tb/sim_pfifo_top.sv
`timescale 1ns/1ps
module sim_pfifo_top;
    import pfb_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        hold = 1'b0;
    logic        wr = 1'b0;
    logic        rd = 1'b0;
    logic [71:0] wd = '0;
    logic [35:0] rd0;
    logic [71:0] rd1;
    logic        fn [2];
    logic        afn [2];
    logic        en [2];
    logic [71:0] rdat [2];

    int vectors = 0;
    int miss = 0;

    logic [71:0] q0 [$];
    logic [71:0] q1 [$];
    bit          g0 = 0;
    bit          g1 = 0;

    always #2.5 clk = ~clk;

    pfifo_top #(.SHAPE(BUS_NARROW)) u0 (
        .clk(clk), .rst(rst), .flush(flush), .hold(hold),
        .wr_en(wr), .wr_data(wd[35:0]), .full_n(fn[0]), .afull_n(afn[0]),
        .rd_en(rd), .rd_data(rd0), .empty_n(en[0])
    );

    pfifo_top #(.SHAPE(BUS_WIDE)) u1 (
        .clk(clk), .rst(rst), .flush(flush), .hold(hold),
        .wr_en(wr), .wr_data(wd), .full_n(fn[1]), .afull_n(afn[1]),
        .rd_en(rd), .rd_data(rd1), .empty_n(en[1])
    );

    assign rdat[0] = {36'b0, rd0};
    assign rdat[1] = rd1;

    task automatic chk(string req, string what, logic [71:0] act, logic [71:0] exp);
        vectors++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s actual=%h expected=%h t=%0t", req, what, act, exp, $time);
        end
    endtask

    // Compare both shapes against the queue model, then advance one clock.
    task automatic cyc(bit w, bit r, bit h, bit f, logic [71:0] d);
        wr = w; rd = r; hold = h; flush = f; wd = d;
        #1;
        for (int s = 0; s < 2; s++) begin
            logic [71:0] q [$];
            logic [71:0] mask;
            bit          g;
            bit          nonempty;
            int          depth;
            if (s == 0) begin q = q0; g = g0; depth = 32; mask = {36'b0, {36{1'b1}}}; end
            else        begin q = q1; g = g1; depth = 16; mask = {72{1'b1}}; end
            nonempty = (q.size() != 0) && (!h || g);
            chk(h ? "R6" : "R5", $sformatf("empty_n shape%0d", s), {71'b0, en[s]}, {71'b0, nonempty});
            chk("R3", $sformatf("full_n shape%0d", s), {71'b0, fn[s]}, {71'b0, q.size() != depth});
            chk("R4", $sformatf("afull_n shape%0d", s), {71'b0, afn[s]}, {71'b0, (depth - q.size()) > 4});
            if (nonempty) chk("R2", $sformatf("rd_data shape%0d", s), rdat[s], q[0] & mask);
            if (f) begin
                q.delete();
                g = 0;
            end else begin
                bit wok;
                wok = w && (q.size() < depth);
                if (r && nonempty) void'(q.pop_front());
                if (wok) q.push_back(d & mask);
                if (q.size() == depth) g = 1;
                else if (q.size() == 0) g = 0;
            end
            if (s == 0) begin q0 = q; g0 = g; end
            else        begin q1 = q; g1 = g; end
        end
        @(posedge clk);
        #1;
    endtask

    function automatic logic [71:0] word(int i);
        return {8'hA5, 32'(i) * 32'h9E3779B1, 32'(i)};
    endfunction

    initial begin
        #(200000 * 5);
        miss++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

    initial begin
        int n;
        logic [15:0] lf;
        n = 0;
        repeat (4) @(posedge clk);
        #1;
        rst = 1'b0;
        // R9: reset state of both shapes
        for (int s = 0; s < 2; s++) begin
            chk("R9", "empty_n after reset", {71'b0, en[s]}, 72'd0);
            chk("R9", "full_n after reset", {71'b0, fn[s]}, 72'd1);
            chk("R9", "afull_n after reset", {71'b0, afn[s]}, 72'd1);
        end

        // R5: reads against an empty buffer are ignored
        repeat (3) cyc(0, 1, 0, 0, '0);

        // R2: streaming with interleaved reads
        for (int i = 0; i < 20; i++) cyc(1, (i % 3) == 2, 0, 0, word(n++));
        repeat (20) cyc(0, 1, 0, 0, '0);

        // R1, R3, R4: fill both shapes past full, checking capacity
        for (int i = 1; i <= 40; i++) begin
            cyc(1, 0, 0, 0, word(n++));
            if (i == 15) chk("R1", "wide not full at 15", {71'b0, fn[1]}, 72'd1);
            if (i == 16) chk("R1", "wide full at 16", {71'b0, fn[1]}, 72'd0);
            if (i == 31) chk("R1", "narrow not full at 31", {71'b0, fn[0]}, 72'd1);
            if (i == 32) chk("R1", "narrow full at 32", {71'b0, fn[0]}, 72'd0);
        end
        // R3: read and write at full; only the read takes effect
        repeat (3) cyc(1, 1, 0, 0, word(n++));
        // R5: drain past empty
        repeat (40) cyc(0, 1, 0, 0, '0);

        // R7: paired accesses at the almost-full edge of the narrow shape
        cyc(0, 0, 0, 1, '0);
        for (int i = 0; i < 28; i++) cyc(1, 0, 0, 0, word(n++));
        for (int i = 0; i < 6; i++) begin
            cyc(1, 1, 0, 0, word(n++));
            chk("R7", "narrow afull_n held at 4 free", {71'b0, afn[0]}, 72'd0);
            chk("R7", "narrow full_n held at 4 free", {71'b0, fn[0]}, 72'd1);
        end
        cyc(1, 0, 0, 0, word(n++));
        cyc(0, 1, 0, 0, '0);
        cyc(0, 1, 0, 0, '0);

        // R8: flush with a coinciding write
        cyc(1, 1, 0, 1, word(n++));
        for (int s = 0; s < 2; s++) begin
            chk("R8", "empty_n after flush", {71'b0, en[s]}, 72'd0);
            chk("R8", "afull_n after flush", {71'b0, afn[s]}, 72'd1);
        end

        // R6: hold-off with reads requested throughout
        for (int i = 0; i < 40; i++) cyc(1, 1, 1, 0, word(n++));
        repeat (40) cyc(0, 1, 1, 0, '0);
        for (int i = 0; i < 10; i++) cyc(1, 0, 1, 0, word(n++));
        // R8: flush closes the gate; refill under hold stays reported empty
        cyc(0, 0, 1, 1, '0);
        for (int i = 0; i < 8; i++) cyc(1, 1, 1, 0, word(n++));
        chk("R8", "narrow gate closed after flush", {71'b0, en[0]}, 72'd0);
        cyc(0, 0, 0, 1, '0);

        // Mixed traffic from a pseudo-random sequence
        lf = 16'hACE1;
        for (int i = 0; i < 4000; i++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            cyc(lf[0] | lf[3], lf[1] & (lf[5] | (i > 2000)), (i / 500) % 2 == 1,
                lf[15:9] == 7'h5A, word(n++));
        end

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
        $finish;
    end

endmodule